// File: doc/BRIEF.md
# Multi-Level Address Translation Cache

This block holds completed address translations for an I/O memory management unit. It is a small, fully associative store. Each entry carries a tag and a payload. The tag is made of an address-space identifier, a virtual-machine identifier, an input base address aligned to the entry's own span, a two-bit granule code and the table level the translation came from. The payload is an output base address, the span mask and two permission bits. A separate table walker fills the cache through the insert port. Software-driven maintenance removes entries through the command port.

A lookup takes a translation context: both identifiers, a granule code and a region-size field `lk_tsz`. It also takes an input address. From the context the block computes the coarsest table level that can exist, then probes one level per clock cycle, masking the address to that level's span. The first level that matches ends the probe. The block pulses `lk_done`, with `lk_hit` telling whether a translation was found. Running hit and miss totals are kept.

The command port clears the whole cache, or every entry of one address space, or every entry of one virtual machine. It can also remove entries that overlap an address range. Each identifier can be made a wildcard for the range case. When a level hint is given, a narrower exact-tag removal is tried first. Every command takes a single cycle. A walking probe stands still during that cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `hit_cnt` and `miss_cnt` are zero, `lk_busy` and `lk_done` are low, and any lookup misses.
- R2: An accepted lookup starts at level max(0, min(4, 4 − (isz − 4)/st)). Here isz = 64 − `lk_tsz`, st = g − 3, and the granule log2 g = 2·code + 10, so code 1 is 4 KB, 2 is 16 KB and 3 is 64 KB. The lookup spends one cycle per level up to level 3. `lk_done` rises after as many cycles as levels probed, and the first matching level wins.
- R3: On a hit, `lk_out_addr` and `lk_perm` are the stored output base and permissions. `lk_out_mask` is 2^s − 1, where s = g + (3 − level)·(g − 3).
- R4: An entry matches only if its address-space ID, virtual-machine ID, granule code and level all equal the probe's, and the probe address with its low s bits cleared equals the entry base.
- R5: Each completed lookup adds one to `hit_cnt` on a hit, or one to `miss_cnt` on a miss.
- R6: An insert stores its address aligned to the entry span, in the lowest free slot. If no slot is free, every entry is dropped first and the new one is written.
- R7: Command code 0 removes every entry.
- R8: Command code 1 removes all entries with a matching address-space ID. Command code 2 removes all entries with a matching virtual-machine ID.
- R9: Command code 3 is the range command. A granule code of 0 means a 4 KB granule, so the shift is 12; otherwise the shift is 2·code + 10. The range mask is (pages << shift) − 1. An entry is removed if its identifiers match or are wildcarded, and if either the command address with the entry's span bits cleared equals the entry base, or the entry base with the range bits cleared equals the command address.
- R10: For code 3 with a nonzero level hint, pages equal to 1 and a concrete address-space ID, only entries whose full tag equals {IDs, address, granule code, hint} are removed. If there is no such entry, the range rule of R9 applies instead.
- R11: A command in a cycle where a probe is walking holds the probe at its level for that cycle. A command and an insert in the same cycle act as the command applied to the old contents, followed by the insert.
- R12: A context whose start level computes to 4 finishes as a miss after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Start a lookup (taken when not busy) |
| lk_asid | input | 16 | Lookup address-space ID |
| lk_vmid | input | 16 | Lookup virtual-machine ID |
| lk_addr | input | 48 | Lookup input address |
| lk_gcode | input | 2 | Lookup granule code (1/2/3 = 4K/16K/64K) |
| lk_tsz | input | 6 | Lookup region-size field; input size = 64 − value |
| lk_busy | output | 1 | A probe is walking |
| lk_done | output | 1 | One-cycle pulse: lookup finished |
| lk_hit | output | 1 | Finished lookup found an entry |
| lk_out_addr | output | 48 | Output base of the hit entry |
| lk_out_mask | output | 48 | Span mask of the hit entry |
| lk_perm | output | 2 | Permissions of the hit entry |
| hit_cnt | output | 16 | Lookup hits since reset |
| miss_cnt | output | 16 | Lookup misses since reset |
| ins_valid | input | 1 | Write an entry |
| ins_asid | input | 16 | New entry address-space ID |
| ins_vmid | input | 16 | New entry virtual-machine ID |
| ins_addr | input | 48 | New entry input address (aligned on write) |
| ins_gcode | input | 2 | New entry granule code |
| ins_level | input | 2 | New entry table level |
| ins_out | input | 48 | New entry output base |
| ins_perm | input | 2 | New entry permissions |
| cmd_valid | input | 1 | Execute an invalidation command |
| cmd_op | input | 2 | 0 all, 1 by address space, 2 by virtual machine, 3 range |
| cmd_asid | input | 16 | Command address-space ID |
| cmd_asid_any | input | 1 | Address-space ID is a wildcard |
| cmd_vmid | input | 16 | Command virtual-machine ID |
| cmd_vmid_any | input | 1 | Virtual-machine ID is a wildcard |
| cmd_addr | input | 48 | Range start address |
| cmd_gcode | input | 2 | Range granule code (0 = 4 KB) |
| cmd_pages | input | 8 | Range page count |
| cmd_ttl | input | 2 | Level hint (0 = none) |

## Verification
An invalidation command can arrive while a lookup is walking its levels. The bench provokes this by issuing an address-space command that touches no entry in the cycle after a lookup is accepted. It judges the result by the hit still being reported, with the done pulse exactly one cycle later than for the same lookup alone. An insert can also share a cycle with a clear-all command. That case is judged by the new entry hitting afterwards while an older one misses.

// File: rtl/xc_pkg.sv
package xc_pkg;

    parameter int ADDR_W = 48;
    parameter int ID_W   = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ID_W-1:0]   id_t;

    typedef enum logic [1:0] {
        INV_ALL   = 2'd0,
        INV_ASID  = 2'd1,
        INV_VMID  = 2'd2,
        INV_RANGE = 2'd3
    } inv_op_e;

    typedef struct packed {
        id_t        asid;
        id_t        vmid;
        addr_t      base;
        logic [1:0] gcode;
        logic [1:0] level;
        addr_t      out;
        logic [1:0] perm;
        addr_t      mask;
    } entry_t;

    function automatic int gran_log2(input logic [1:0] gc);
        return 2 * int'(gc) + 10;
    endfunction

    function automatic int level_shift(input logic [1:0] gc, input logic [1:0] lvl);
        int g;
        g = gran_log2(gc);
        return g + (3 - int'(lvl)) * (g - 3);
    endfunction

    function automatic addr_t span_mask(input int sh);
        if (sh >= ADDR_W) return '1;
        return (addr_t'(1) << sh) - addr_t'(1);
    endfunction

    function automatic logic [2:0] first_level(input logic [1:0] gc, input logic [5:0] tsz);
        int isz;
        int stride;
        int lv;
        isz    = 64 - int'(tsz);
        stride = gran_log2(gc) - 3;
        lv     = 4 - (isz - 4) / stride;
        if (lv < 0) lv = 0;
        if (lv > 4) lv = 4;
        return 3'(lv);
    endfunction

endpackage

// File: rtl/xc_tag_match.sv
module xc_tag_match
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  entry_t             ents [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    input  id_t                asid,
    input  id_t                vmid,
    input  addr_t              addr,
    input  logic [1:0]         gcode,
    input  logic [1:0]         level,
    output logic [ENTRIES-1:0] hit_vec
);

    addr_t lvl_mask;
    addr_t probe_base;

    always_comb begin
        lvl_mask   = span_mask(level_shift(gcode, level));
        probe_base = addr & ~lvl_mask;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = valid[i]
                          && (ents[i].asid  == asid)
                          && (ents[i].vmid  == vmid)
                          && (ents[i].gcode == gcode)
                          && (ents[i].level == level)
                          && (ents[i].base  == probe_base);
    end

endmodule

// File: rtl/xc_entry_store.sv
module xc_entry_store
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PAGES_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_valid,
    input  id_t                ins_asid,
    input  id_t                ins_vmid,
    input  addr_t              ins_addr,
    input  logic [1:0]         ins_gcode,
    input  logic [1:0]         ins_level,
    input  addr_t              ins_out,
    input  logic [1:0]         ins_perm,
    input  logic               cmd_valid,
    input  inv_op_e            cmd_op,
    input  id_t                cmd_asid,
    input  logic               cmd_asid_any,
    input  id_t                cmd_vmid,
    input  logic               cmd_vmid_any,
    input  addr_t              cmd_addr,
    input  logic [1:0]         cmd_gcode,
    input  logic [PAGES_W-1:0] cmd_pages,
    input  logic [1:0]         cmd_ttl,
    output entry_t             ents [ENTRIES],
    output logic [ENTRIES-1:0] valid
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] by_asid, by_vmid, exact, in_range, kill, survive, valid_nx;
    logic               use_exact, full;
    logic [IDX_W-1:0]   free_idx, slot;
    addr_t              rng_mask;
    entry_t             fresh;
    int                 rng_shift;

    always_comb begin
        rng_shift = (cmd_gcode == 2'd0) ? 12 : gran_log2(cmd_gcode);
        rng_mask  = (addr_t'(cmd_pages) << rng_shift) - addr_t'(1);
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
        logic asid_ok, vmid_ok, overlap;
        assign asid_ok    = cmd_asid_any || (ents[i].asid == cmd_asid);
        assign vmid_ok    = cmd_vmid_any || (ents[i].vmid == cmd_vmid);
        assign overlap    = ((cmd_addr & ~ents[i].mask) == ents[i].base)
                         || ((ents[i].base & ~rng_mask) == cmd_addr);
        assign by_asid[i] = valid[i] && (ents[i].asid == cmd_asid);
        assign by_vmid[i] = valid[i] && (ents[i].vmid == cmd_vmid);
        assign exact[i]   = valid[i] && !cmd_asid_any && !cmd_vmid_any
                         && (ents[i].asid  == cmd_asid)
                         && (ents[i].vmid  == cmd_vmid)
                         && (ents[i].base  == cmd_addr)
                         && (ents[i].gcode == cmd_gcode)
                         && (ents[i].level == cmd_ttl);
        assign in_range[i] = valid[i] && asid_ok && vmid_ok && overlap;
    end

    always_comb begin
        use_exact = (cmd_ttl != 2'd0) && (cmd_pages == PAGES_W'(1))
                 && !cmd_asid_any && (|exact);
        kill = '0;
        if (cmd_valid) begin
            unique case (cmd_op)
                INV_ALL:   kill = '1;
                INV_ASID:  kill = by_asid;
                INV_VMID:  kill = by_vmid;
                INV_RANGE: kill = use_exact ? exact : in_range;
                default:   kill = '0;
            endcase
        end
        survive  = valid & ~kill;
        full     = &survive;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!survive[i]) free_idx = IDX_W'(i);
        end
        slot     = full ? '0 : free_idx;
        valid_nx = survive;
        if (ins_valid) begin
            if (full) valid_nx = '0;
            valid_nx[slot] = 1'b1;
        end
        fresh.asid  = ins_asid;
        fresh.vmid  = ins_vmid;
        fresh.gcode = ins_gcode;
        fresh.level = ins_level;
        fresh.out   = ins_out;
        fresh.perm  = ins_perm;
        fresh.mask  = span_mask(level_shift(ins_gcode, ins_level));
        fresh.base  = ins_addr & ~fresh.mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else begin
            valid <= valid_nx;
            if (ins_valid) ents[slot] <= fresh;
        end
    end

    // R7: a clear-all with no insert leaves nothing valid
    a_r7_clear_all_empties: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_op == INV_ALL) && !ins_valid |=> (valid == '0));

    // R6: insert into a full store keeps only the new entry
    a_r6_full_insert_single: assert property (@(posedge clk) disable iff (rst)
        ins_valid && !cmd_valid && (&valid) |=> ($countones(valid) == 1));

    // R6: insert with a free slot grows occupancy by one
    a_r6_insert_grows: assert property (@(posedge clk) disable iff (rst)
        ins_valid && !cmd_valid && !(&valid)
        |=> ($countones(valid) == $past($countones(valid)) + 1));

    // R11: an insert always survives a command in the same cycle
    a_r11_insert_survives: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> (valid != '0));

endmodule

// File: rtl/xc_probe_fsm.sv
module xc_probe_fsm
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_req,
    input  id_t                lk_asid,
    input  id_t                lk_vmid,
    input  addr_t              lk_addr,
    input  logic [1:0]         lk_gcode,
    input  logic [5:0]         lk_tsz,
    input  logic               stall,
    input  logic [ENTRIES-1:0] hit_vec,
    input  entry_t             ents [ENTRIES],
    output id_t                pr_asid,
    output id_t                pr_vmid,
    output addr_t              pr_addr,
    output logic [1:0]         pr_gcode,
    output logic [2:0]         pr_level,
    output logic               busy,
    output logic               done,
    output logic               hit,
    output addr_t              out_addr,
    output addr_t              out_mask,
    output logic [1:0]         out_perm,
    output logic [CNT_W-1:0]   hit_cnt,
    output logic [CNT_W-1:0]   miss_cnt
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef enum logic {P_IDLE, P_WALK} pstate_e;
    pstate_e          st;
    logic [IDX_W-1:0] sel;
    logic             any_hit, past_end, last_lvl;

    always_comb begin
        any_hit  = |hit_vec;
        past_end = pr_level > 3'd3;
        last_lvl = pr_level == 3'd3;
        sel      = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
    end

    assign busy = (st == P_WALK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= P_IDLE;
            done     <= 1'b0;
            hit      <= 1'b0;
            out_addr <= '0;
            out_mask <= '0;
            out_perm <= '0;
            hit_cnt  <= '0;
            miss_cnt <= '0;
            pr_asid  <= '0;
            pr_vmid  <= '0;
            pr_addr  <= '0;
            pr_gcode <= '0;
            pr_level <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                P_IDLE: if (lk_req) begin
                    pr_asid  <= lk_asid;
                    pr_vmid  <= lk_vmid;
                    pr_addr  <= lk_addr;
                    pr_gcode <= lk_gcode;
                    pr_level <= first_level(lk_gcode, lk_tsz);
                    st       <= P_WALK;
                end
                P_WALK: if (!stall) begin
                    if (past_end || (!any_hit && last_lvl)) begin
                        done     <= 1'b1;
                        hit      <= 1'b0;
                        miss_cnt <= miss_cnt + CNT_W'(1);
                        st       <= P_IDLE;
                    end else if (any_hit) begin
                        done     <= 1'b1;
                        hit      <= 1'b1;
                        out_addr <= ents[sel].out;
                        out_mask <= ents[sel].mask;
                        out_perm <= ents[sel].perm;
                        hit_cnt  <= hit_cnt + CNT_W'(1);
                        st       <= P_IDLE;
                    end else begin
                        pr_level <= pr_level + 3'd1;
                    end
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    // R11: a command holds the walking probe at its level
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
        busy && stall |=> busy && (pr_level == $past(pr_level)));

    // R2: an unstalled probe either finishes or climbs one level
    a_r2_one_level_per_cycle: assert property (@(posedge clk) disable iff (rst)
        busy && !stall |=> !busy || (pr_level == $past(pr_level) + 3'd1));

    // R2: completion only follows a walking cycle
    a_r2_done_after_walk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R5: a hit bumps the hit total and leaves the miss total
    a_r5_hit_counted: assert property (@(posedge clk) disable iff (rst)
        done && hit |-> (hit_cnt == $past(hit_cnt) + CNT_W'(1)) && $stable(miss_cnt));

    // R5: a miss bumps the miss total and leaves the hit total
    a_r5_miss_counted: assert property (@(posedge clk) disable iff (rst)
        done && !hit |-> (miss_cnt == $past(miss_cnt) + CNT_W'(1)) && $stable(hit_cnt));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16,
    parameter int PAGES_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lk_req,
    input  logic [ID_W-1:0]        lk_asid,
    input  logic [ID_W-1:0]        lk_vmid,
    input  logic [ADDR_W-1:0]      lk_addr,
    input  logic [1:0]             lk_gcode,
    input  logic [5:0]             lk_tsz,
    output logic                   lk_busy,
    output logic                   lk_done,
    output logic                   lk_hit,
    output logic [ADDR_W-1:0]      lk_out_addr,
    output logic [ADDR_W-1:0]      lk_out_mask,
    output logic [1:0]             lk_perm,
    output logic [CNT_W-1:0]       hit_cnt,
    output logic [CNT_W-1:0]       miss_cnt,
    input  logic                   ins_valid,
    input  logic [ID_W-1:0]        ins_asid,
    input  logic [ID_W-1:0]        ins_vmid,
    input  logic [ADDR_W-1:0]      ins_addr,
    input  logic [1:0]             ins_gcode,
    input  logic [1:0]             ins_level,
    input  logic [ADDR_W-1:0]      ins_out,
    input  logic [1:0]             ins_perm,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [ID_W-1:0]        cmd_asid,
    input  logic                   cmd_asid_any,
    input  logic [ID_W-1:0]        cmd_vmid,
    input  logic                   cmd_vmid_any,
    input  logic [ADDR_W-1:0]      cmd_addr,
    input  logic [1:0]             cmd_gcode,
    input  logic [PAGES_W-1:0]     cmd_pages,
    input  logic [1:0]             cmd_ttl
);

    entry_t             ents [ENTRIES];
    logic [ENTRIES-1:0] valid, hit_vec;
    id_t                pr_asid, pr_vmid;
    addr_t              pr_addr;
    logic [1:0]         pr_gcode;
    logic [2:0]         pr_level;

    xc_entry_store #(.ENTRIES(ENTRIES), .PAGES_W(PAGES_W)) i_store (
        .clk, .rst,
        .ins_valid, .ins_asid, .ins_vmid, .ins_addr, .ins_gcode, .ins_level,
        .ins_out, .ins_perm,
        .cmd_valid, .cmd_op(inv_op_e'(cmd_op)), .cmd_asid, .cmd_asid_any,
        .cmd_vmid, .cmd_vmid_any, .cmd_addr, .cmd_gcode, .cmd_pages, .cmd_ttl,
        .ents, .valid
    );

    xc_tag_match #(.ENTRIES(ENTRIES)) i_match (
        .ents, .valid,
        .asid(pr_asid), .vmid(pr_vmid), .addr(pr_addr), .gcode(pr_gcode),
        .level(pr_level[1:0]), .hit_vec
    );

    xc_probe_fsm #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) i_probe (
        .clk, .rst,
        .lk_req, .lk_asid, .lk_vmid, .lk_addr, .lk_gcode, .lk_tsz,
        .stall(cmd_valid), .hit_vec, .ents,
        .pr_asid, .pr_vmid, .pr_addr, .pr_gcode, .pr_level,
        .busy(lk_busy), .done(lk_done), .hit(lk_hit),
        .out_addr(lk_out_addr), .out_mask(lk_out_mask), .out_perm(lk_perm),
        .hit_cnt, .miss_cnt
    );

endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/100ps
module test_xlat_cache;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req = 0;
    logic [15:0] lk_asid = 0, lk_vmid = 0;
    logic [47:0] lk_addr = 0;
    logic [1:0]  lk_gcode = 0;
    logic [5:0]  lk_tsz = 0;
    logic        lk_busy, lk_done, lk_hit;
    logic [47:0] lk_out_addr, lk_out_mask;
    logic [1:0]  lk_perm;
    logic [15:0] hit_cnt, miss_cnt;
    logic        ins_valid = 0;
    logic [15:0] ins_asid = 0, ins_vmid = 0;
    logic [47:0] ins_addr = 0, ins_out = 0;
    logic [1:0]  ins_gcode = 0, ins_level = 0, ins_perm = 0;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_op = 0;
    logic [15:0] cmd_asid = 0, cmd_vmid = 0;
    logic        cmd_asid_any = 0, cmd_vmid_any = 0;
    logic [47:0] cmd_addr = 0;
    logic [1:0]  cmd_gcode = 0, cmd_ttl = 0;
    logic [7:0]  cmd_pages = 0;

    always #2.5 clk = ~clk;

    xlat_cache i_xlat_cache (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic        r_hit;
    int          r_lat;
    logic [47:0] r_out, r_mask;
    logic [1:0]  r_perm;

    typedef struct packed {
        logic [15:0] asid;
        logic [15:0] vmid;
        logic [1:0]  g;
        logic [5:0]  tsz;
        logic [47:0] addr;
        logic        hit;
        logic [47:0] out;
        logic [47:0] mask;
        logic [1:0]  perm;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_4123_4567, 1'b1, 48'h0000_8000_0000, 48'h0000_3FFF_FFFF, 2'd3, 4'd2},
        '{16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_0020_3ABC, 1'b1, 48'h0000_1234_5000, 48'h0000_0000_0FFF, 2'd1, 4'd4},
        '{16'd2, 16'd5, 2'd1, 6'd16, 48'h0000_0067_8000, 1'b1, 48'h0000_0AA0_0000, 48'h0000_001F_FFFF, 2'd2, 4'd3},
        '{16'd2, 16'd4, 2'd1, 6'd16, 48'h0000_0067_8000, 1'b0, 48'h0, 48'h0, 2'd0, 4'd4},
        '{16'd3, 16'd0, 2'd1, 6'd16, 48'h0000_4123_4567, 1'b0, 48'h0, 48'h0, 2'd0, 4'd4},
        '{16'd1, 16'd0, 2'd2, 6'd16, 48'h0000_4123_4567, 1'b0, 48'h0, 48'h0, 2'd0, 4'd4},
        '{16'd1, 16'd0, 2'd3, 6'd16, 48'h0000_0007_FFFF, 1'b1, 48'h0000_0BB7_0000, 48'h0000_0000_FFFF, 2'd1, 4'd3},
        '{16'd1, 16'd0, 2'd1, 6'd60, 48'h0000_4123_4567, 1'b0, 48'h0, 48'h0, 2'd0, 4'd1}
    };

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic lookup(input logic [15:0] a, input logic [15:0] v, input logic [1:0] g,
                          input logic [5:0] t, input logic [47:0] ad, input bit inject);
        @(negedge clk);
        lk_req = 1; lk_asid = a; lk_vmid = v; lk_gcode = g; lk_tsz = t; lk_addr = ad;
        @(negedge clk);
        lk_req = 0;
        if (inject) begin
            cmd_valid = 1; cmd_op = 2'd1; cmd_asid = 16'd99; cmd_asid_any = 0;
        end
        r_lat = 0;
        while (!lk_done && r_lat < 20) begin
            @(negedge clk);
            cmd_valid = 0;
            r_lat++;
        end
        r_hit = lk_hit; r_out = lk_out_addr; r_mask = lk_out_mask; r_perm = lk_perm;
    endtask

    task automatic expect_lk(input string req, input logic hit, input int lat,
                             input logic [47:0] out, input logic [47:0] mask, input logic [1:0] perm);
        chk(r_hit == hit, {req, " hit"}, 64'(r_hit), 64'(hit));
        chk(r_lat == lat, {req, " latency"}, 64'(r_lat), 64'(lat));
        if (hit) begin
            chk(r_out == out && r_mask == mask && r_perm == perm, {req, " out/mask/perm"},
                {r_out[31:0], r_mask[29:0], r_perm}, {out[31:0], mask[29:0], perm});
        end
    endtask

    task automatic set_ins(input logic [15:0] a, input logic [15:0] v, input logic [47:0] ad,
                           input logic [1:0] g, input logic [1:0] lvl, input logic [47:0] o, input logic [1:0] p);
        ins_valid = 1; ins_asid = a; ins_vmid = v; ins_addr = ad;
        ins_gcode = g; ins_level = lvl; ins_out = o; ins_perm = p;
    endtask

    task automatic ins(input logic [15:0] a, input logic [15:0] v, input logic [47:0] ad,
                       input logic [1:0] g, input logic [1:0] lvl, input logic [47:0] o, input logic [1:0] p);
        @(negedge clk);
        set_ins(a, v, ad, g, lvl, o, p);
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic set_cmd(input logic [1:0] op, input logic [15:0] a, input bit a_any,
                           input logic [15:0] v, input bit v_any, input logic [47:0] ad,
                           input logic [1:0] g, input logic [7:0] pg, input logic [1:0] ttl);
        cmd_valid = 1; cmd_op = op; cmd_asid = a; cmd_asid_any = a_any;
        cmd_vmid = v; cmd_vmid_any = v_any; cmd_addr = ad; cmd_gcode = g;
        cmd_pages = pg; cmd_ttl = ttl;
    endtask

    task automatic inv(input logic [1:0] op, input logic [15:0] a, input bit a_any,
                       input logic [15:0] v, input bit v_any, input logic [47:0] ad,
                       input logic [1:0] g, input logic [7:0] pg, input logic [1:0] ttl);
        @(negedge clk);
        set_cmd(op, a, a_any, v, v_any, ad, g, pg, ttl);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state and an empty cache
        chk(!lk_busy && !lk_done, "R1 busy/done idle", {lk_busy, lk_done}, 0);
        chk(hit_cnt == 0 && miss_cnt == 0, "R1 counters zero", {hit_cnt, miss_cnt}, 0);
        lookup(16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_4123_4567, 0);
        expect_lk("R1 empty lookup", 0, 4, 0, 0, 0);

        // R6: unaligned insert address is aligned on write
        ins(16'd1, 16'd0, 48'h0000_4000_0123, 2'd1, 2'd1, 48'h0000_8000_0000, 2'd3);
        ins(16'd1, 16'd0, 48'h0000_0020_3000, 2'd1, 2'd3, 48'h0000_1234_5000, 2'd1);
        ins(16'd2, 16'd5, 48'h0000_0060_0000, 2'd1, 2'd2, 48'h0000_0AA0_0000, 2'd2);
        ins(16'd1, 16'd0, 48'h0000_0007_0000, 2'd3, 2'd3, 48'h0000_0BB7_0000, 2'd1);

        // R2 R3 R4 R12: vector table
        for (int k = 0; k < 8; k++) begin
            lookup(VECS[k].asid, VECS[k].vmid, VECS[k].g, VECS[k].tsz, VECS[k].addr, 0);
            expect_lk($sformatf("R2/R3/R4/R12 vec%0d", k), VECS[k].hit, int'(VECS[k].lat),
                      VECS[k].out, VECS[k].mask, VECS[k].perm);
        end

        // R5: totals (4 table hits, 4 table misses plus the empty lookup)
        chk(hit_cnt == 16'd4, "R5 hit total", 64'(hit_cnt), 4);
        chk(miss_cnt == 16'd5, "R5 miss total", 64'(miss_cnt), 5);

        // R9: wildcard range, entry base falls inside the range
        inv(2'd3, 16'd0, 1, 16'd0, 1, 48'h0000_0020_0000, 2'd0, 8'd4, 2'd0);
        lookup(16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_0020_3ABC, 0);
        expect_lk("R9 range removed page", 0, 4, 0, 0, 0);
        lookup(16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_4123_4567, 0);
        expect_lk("R9 range kept block", 1, 2, 48'h0000_8000_0000, 48'h0000_3FFF_FFFF, 2'd3);
        // R9: request address inside a larger entry
        inv(2'd3, 16'd1, 0, 16'd0, 1, 48'h0000_4000_5000, 2'd1, 8'd1, 2'd0);
        lookup(16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_4123_4567, 0);
        expect_lk("R9 range removed block", 0, 4, 0, 0, 0);
        lookup(16'd2, 16'd5, 2'd1, 6'd16, 48'h0000_0067_8000, 0);
        expect_lk("R9 other asid kept", 1, 3, 48'h0000_0AA0_0000, 48'h0000_001F_FFFF, 2'd2);

        // R10: exact-tag path removes only the hinted level
        ins(16'd1, 16'd0, 48'h0000_0080_0000, 2'd1, 2'd2, 48'h0000_0BC0_0000, 2'd2);
        ins(16'd1, 16'd0, 48'h0000_0080_0000, 2'd1, 2'd3, 48'h0000_0CC0_0000, 2'd1);
        inv(2'd3, 16'd1, 0, 16'd0, 0, 48'h0000_0080_0000, 2'd1, 8'd1, 2'd2);
        lookup(16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_0080_0123, 0);
        expect_lk("R10 exact kept finer", 1, 4, 48'h0000_0CC0_0000, 48'h0000_0000_0FFF, 2'd1);
        // R10: hint with no exact match falls back to range scan
        inv(2'd3, 16'd1, 0, 16'd0, 0, 48'h0000_0080_0000, 2'd1, 8'd1, 2'd1);
        lookup(16'd1, 16'd0, 2'd1, 6'd16, 48'h0000_0080_0123, 0);
        expect_lk("R10 fallback removed", 0, 4, 0, 0, 0);

        // R8: by address space, then by virtual machine
        ins(16'd7, 16'd3, 48'h0000_0100_0000, 2'd1, 2'd3, 48'h0000_0011_1000, 2'd1);
        ins(16'd8, 16'd3, 48'h0000_0100_0000, 2'd1, 2'd3, 48'h0000_0022_2000, 2'd2);
        ins(16'd7, 16'd9, 48'h0000_0100_0000, 2'd1, 2'd3, 48'h0000_0033_3000, 2'd3);
        inv(2'd1, 16'd7, 0, 16'd0, 0, 48'h0, 2'd0, 8'd0, 2'd0);
        lookup(16'd7, 16'd3, 2'd1, 6'd16, 48'h0000_0100_0000, 0);
        expect_lk("R8 asid removed a", 0, 4, 0, 0, 0);
        lookup(16'd7, 16'd9, 2'd1, 6'd16, 48'h0000_0100_0000, 0);
        expect_lk("R8 asid removed b", 0, 4, 0, 0, 0);
        lookup(16'd8, 16'd3, 2'd1, 6'd16, 48'h0000_0100_0000, 0);
        expect_lk("R8 asid kept other", 1, 4, 48'h0000_0022_2000, 48'h0000_0000_0FFF, 2'd2);
        inv(2'd2, 16'd0, 0, 16'd3, 0, 48'h0, 2'd0, 8'd0, 2'd0);
        lookup(16'd8, 16'd3, 2'd1, 6'd16, 48'h0000_0100_0000, 0);
        expect_lk("R8 vmid removed", 0, 4, 0, 0, 0);
        lookup(16'd2, 16'd5, 2'd1, 6'd16, 48'h0000_0067_8000, 0);
        expect_lk("R8 vmid kept other", 1, 3, 48'h0000_0AA0_0000, 48'h0000_001F_FFFF, 2'd2);

        // R7: clear all
        inv(2'd0, 16'd0, 0, 16'd0, 0, 48'h0, 2'd0, 8'd0, 2'd0);
        lookup(16'd2, 16'd5, 2'd1, 6'd16, 48'h0000_0067_8000, 0);
        expect_lk("R7 cleared a", 0, 3 + 1, 0, 0, 0);
        lookup(16'd1, 16'd0, 2'd3, 6'd16, 48'h0000_0007_FFFF, 0);
        expect_lk("R7 cleared b", 0, 3, 0, 0, 0);

        // R6: fill, then overflow clears everything first
        for (int k = 0; k < 8; k++)
            ins(16'd10, 16'd0, 48'(k) << 12, 2'd1, 2'd3, 48'(k + 1) << 20, 2'd1);
        lookup(16'd10, 16'd0, 2'd1, 6'd16, 48'h0000_0000_0ABC, 0);
        expect_lk("R6 full store hit", 1, 4, 48'h0000_0010_0000, 48'h0000_0000_0FFF, 2'd1);
        ins(16'd10, 16'd0, 48'h0000_0000_9000, 2'd1, 2'd3, 48'h0000_0090_0000, 2'd2);
        lookup(16'd10, 16'd0, 2'd1, 6'd16, 48'h0000_0000_1000, 0);
        expect_lk("R6 overflow dropped old", 0, 4, 0, 0, 0);
        lookup(16'd10, 16'd0, 2'd1, 6'd16, 48'h0000_0000_9FFF, 0);
        expect_lk("R6 overflow kept new", 1, 4, 48'h0000_0090_0000, 48'h0000_0000_0FFF, 2'd2);

        // R11: command during a walk costs exactly one cycle
        lookup(16'd10, 16'd0, 2'd1, 6'd16, 48'h0000_0000_9FFF, 1);
        expect_lk("R11 stalled walk", 1, 5, 48'h0000_0090_0000, 48'h0000_0000_0FFF, 2'd2);
        // R11: clear-all and insert in one cycle keep the insert
        @(negedge clk);
        set_cmd(2'd0, 16'd0, 0, 16'd0, 0, 48'h0, 2'd0, 8'd0, 2'd0);
        set_ins(16'd11, 16'd0, 48'h0000_0000_5000, 2'd1, 2'd3, 48'h0000_0077_7000, 2'd3);
        @(negedge clk);
        cmd_valid = 0; ins_valid = 0;
        lookup(16'd11, 16'd0, 2'd1, 6'd16, 48'h0000_0000_5123, 0);
        expect_lk("R11 insert survives clear", 1, 4, 48'h0000_0077_7000, 48'h0000_0000_0FFF, 2'd3);
        lookup(16'd10, 16'd0, 2'd1, 6'd16, 48'h0000_0000_9FFF, 0);
        expect_lk("R11 old entry cleared", 0, 4, 0, 0, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule